// File: doc/BRIEF.md
# Channel Event Flag Register with Read-Armed Clear

This block gathers one-cycle event pulses from a set of timer channels into a memory-mapped status word. Each channel has a sticky flag that hardware raises when an event pulse arrives. Software sees every flag with a single read. It can lower a flag only through a two-step handshake: a read that finds the flag at 1 arms it, and a later write of 0 to that bit clears it.

If an event reaches a channel after the arming read and before the clearing write, the arm for that channel is dropped. The write then leaves the flag at 1, so the new event and its interrupt are kept. The flag vector is also brought out on its own port. A per-channel control register can show the same bits, and both views always agree. Each channel also gives an interrupt request: its flag gated by an enable input.

Top module: `evf_status_reg`

## Requirements
- R1: Channel n's flag sits at bit n of the status word. Bits 8 and above always read as 0, and writing to them changes nothing.
- R2: While reset is high, every flag, every arm, the read data and every interrupt request go to 0 at the next clock edge.
- R3: An event pulse on channel n makes flag n read 1 from the cycle after the pulse onward, until it is cleared.
- R4: A selected read makes rdata_o show, from the next cycle, the flags as they were in the read cycle. The same read arms every channel whose flag was 1.
- R5: A selected write with 0 in bit n clears flag n in the next cycle if channel n is armed. A read followed by a write of 0x00 clears every flag armed by that read.
- R6: Writing 1 to a flag bit never changes that flag.
- R7: Writing 0 to a channel that is not armed leaves its flag unchanged. Every selected write disarms all channels.
- R8: An event on a channel disarms it. This holds when the event comes between the read and the write, and when it comes in the same cycle as the read. The next write then leaves that flag at 1.
- R9: If an event and a clearing write reach the same channel in the same cycle, the flag stays 1.
- R10: irq_o[n] equals flag n ANDed with irq_en_i[n].
- R11: Read and write strobes given while sel_i is low have no effect on flags, arms or read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | NUM_CH | One-cycle event pulse per channel |
| sel_i | input | 1 | Address decode select for this register |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_en_i | input | NUM_CH | Per-channel interrupt enable |
| flag_o | output | NUM_CH | Shared flag vector, mirrored into the per-channel control registers |
| irq_o | output | NUM_CH | Per-channel interrupt request |

## Verification
The main function is driven with a cycle-by-cycle table. It covers:
- single and multi-channel events;
- plain read-then-clear sequences;
- unarmed writes of zero;
- writes of all ones;
- a write that follows an earlier write;
- events placed between the read and the write, in the read cycle itself, and in the write cycle;
- partial clears that pick single bits;
- strobes given without select.

Each pattern separates a different arming or priority rule. For example, an event between the read and the write tells apart a design that disarms on an event from one that clears on the stale arm. A second write tells apart a design that disarms on write from one that keeps arms alive. The interrupt outputs are compared on every step against an enable pattern that mixes 1s and 0s. Reset is tried both at start-up and with flags set.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam int unsigned EVF_NUM_CH = 8;
  localparam int unsigned EVF_DATA_W = 32;

  typedef struct packed {
    logic sel;
    logic rd;
    logic wr;
  } evf_bus_t;
endpackage

// File: rtl/evf_chan_cell.sv
module evf_chan_cell (
  input  logic clk,
  input  logic rst,
  input  logic ev_i,
  input  logic rd_hit_i,
  input  logic wr_hit_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  logic flag_q;
  logic arm_q;
  logic clr_req;

  // Clear only on a write of 0 to an armed flag.
  assign clr_req = wr_hit_i && arm_q && !wr_bit_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (ev_i) begin
      flag_q <= 1'b1;          // set wins over clear
    end else if (clr_req) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
    end else if (ev_i) begin
      arm_q <= 1'b0;           // a fresh event drops the arm
    end else if (wr_hit_i) begin
      arm_q <= 1'b0;           // any write disarms
    end else if (rd_hit_i) begin
      arm_q <= flag_q;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/evf_rd_port.sv
module evf_rd_port #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit_i,
  input  logic [NUM_CH-1:0] flags_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_CH;

  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_hit_i) begin
      rdata_q <= {{PAD_W{1'b0}}, flags_i};
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/evf_irq_gate.sv
module evf_irq_gate #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] flags_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic [NUM_CH-1:0] irq_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_irq
    assign irq_o[g] = flags_i[g] & en_i[g];
  end
endmodule

// File: rtl/evf_status_reg.sv
module evf_status_reg #(
  parameter int unsigned NUM_CH = evf_pkg::EVF_NUM_CH,
  parameter int unsigned DATA_W = evf_pkg::EVF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev_i,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] irq_en_i,
  output logic [NUM_CH-1:0] flag_o,
  output logic [NUM_CH-1:0] irq_o
);
  import evf_pkg::*;

  evf_bus_t bus;
  logic     rd_hit;
  logic     wr_hit;

  assign bus    = '{sel: sel_i, rd: rd_i, wr: wr_i};
  assign rd_hit = bus.sel && bus.rd;
  assign wr_hit = bus.sel && bus.wr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    evf_chan_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .ev_i     (ev_i[g]),
      .rd_hit_i (rd_hit),
      .wr_hit_i (wr_hit),
      .wr_bit_i (wdata_i[g]),
      .flag_o   (flag_o[g])
    );
  end

  evf_rd_port #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_hit_i (rd_hit),
    .flags_i  (flag_o),
    .rdata_o  (rdata_o)
  );

  evf_irq_gate #(.NUM_CH(NUM_CH)) u_irq (
    .flags_i (flag_o),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/evf_status_reg_chk.sv
module evf_status_reg_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ev_i,
  input logic              sel_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NUM_CH-1:0] flag_o
);
  // R2
  reset_clears_chk: assert property (@(posedge clk) rst |=> (flag_o == '0 && rdata_o == '0));

  // R3
  event_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_i != '0) |=> ((flag_o & $past(ev_i)) == $past(ev_i)));

  // R6
  rise_only_by_event_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_o & ~$past(flag_o) & ~$past(ev_i)) == '0));

  // R11
  fall_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel_i && wr_i) |=> ((~flag_o & $past(flag_o)) == '0));

  // R4
  read_returns_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i && rd_i) |=> (rdata_o[NUM_CH-1:0] == $past(flag_o)));

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i && rd_i) |=> (rdata_o[DATA_W-1:NUM_CH] == '0));
endmodule

bind evf_status_reg evf_status_reg_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ev_i    (ev_i),
  .sel_i   (sel_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .rdata_o (rdata_o),
  .flag_o  (flag_o)
);

// File: tb/evf_status_reg_bench.sv
module evf_status_reg_bench;
  localparam int NCH = 8;
  localparam int DW  = 32;
  localparam int NV  = 24;
  // row: ev[26:19] sel[18] rd[17] wr[16] wd[15:8] exp[7:0]
  localparam logic [26:0] VEC [NV] = '{
    {8'h01, 1'b0, 1'b0, 1'b0, 8'h00, 8'h01},
    {8'h82, 1'b0, 1'b0, 1'b0, 8'h00, 8'h83},
    {8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h83},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00},
    {8'h0F, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0F},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h0F},
    {8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h0F},
    {8'h02, 1'b0, 1'b0, 1'b0, 8'h00, 8'h0F},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h02},
    {8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h02},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h02},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h02},
    {8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h02},
    {8'h02, 1'b1, 1'b0, 1'b1, 8'h00, 8'h02},
    {8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h02},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'hFD, 8'h00},
    {8'hF0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hF0},
    {8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'hF0},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'h7F, 8'h70},
    {8'h10, 1'b1, 1'b1, 1'b0, 8'h00, 8'h70},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h10},
    {8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h10},
    {8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 8'h10},
    {8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00}
  };
  localparam logic [NCH-1:0] EN = 8'hA5;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] ev;
  logic sel, rd, wr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] irq_en;
  logic [NCH-1:0] flag;
  logic [NCH-1:0] irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  evf_status_reg u_evf_status_reg (
    .clk      (clk),
    .rst      (rst),
    .ev_i     (ev),
    .sel_i    (sel),
    .rd_i     (rd),
    .wr_i     (wr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .irq_en_i (irq_en),
    .flag_o   (flag),
    .irq_o    (irq)
  );

  function automatic string row_tag(int i);
    case (i)
      0, 1, 4, 16: return "R3";
      2, 6, 17:    return "R4";
      3, 15:       return "R5";
      5:           return "R7";
      7, 8, 19:    return "R8";
      10:          return "R6";
      11:          return "R7";
      13:          return "R9";
      18:          return "R5";
      20:          return "R8";
      22:          return "R11";
      default:     return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev = '0; sel = 1'b0; rd = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [NCH-1:0] prev;
    irq_en = EN;
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    check("R2 flags", {24'b0, flag}, '0);
    check("R2 rdata", rdata, '0);
    check("R2 irq", {24'b0, irq}, '0);

    prev = '0;
    for (int i = 0; i < NV; i++) begin
      ev    = VEC[i][26:19];
      sel   = VEC[i][18];
      rd    = VEC[i][17];
      wr    = VEC[i][16];
      wdata = {24'hFFFFFF, VEC[i][15:8]};   // R1: upper write bits ignored
      @(posedge clk);
      @(negedge clk);
      idle();
      check(row_tag(i), {24'b0, flag}, {24'b0, VEC[i][7:0]});
      // R10
      check("R10 irq", {24'b0, irq}, {24'b0, VEC[i][7:0] & EN});
      if (VEC[i][18] && VEC[i][17]) begin
        // R1 and R4: read shows pre-read flags, upper bits zero
        check("R1 rdata", rdata, {24'b0, prev});
      end
      prev = VEC[i][7:0];
    end

    // R11: unselected read does not update rdata (last selected read saw 8'h10)
    ev = 8'h0C;
    @(posedge clk); @(negedge clk); idle();
    sel = 1'b0; rd = 1'b1;
    @(posedge clk); @(negedge clk); idle();
    check("R11 rdata hold", rdata, 32'h10);

    // R4 and R5: read then 0x00 clears everything armed
    sel = 1'b1; rd = 1'b1;
    @(posedge clk); @(negedge clk); idle();
    check("R4 rdata", rdata, 32'h0C);
    sel = 1'b1; wr = 1'b1; wdata = 32'h0;
    @(posedge clk); @(negedge clk); idle();
    check("R5 clear all", {24'b0, flag}, '0);

    // R2: reset with flags set
    ev = 8'hFF;
    @(posedge clk); @(negedge clk); idle();
    sel = 1'b1; rd = 1'b1;
    @(posedge clk); @(negedge clk); idle();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R2 flags mid", {24'b0, flag}, '0);
    check("R2 rdata mid", rdata, '0);
    check("R2 irq mid", {24'b0, irq}, '0);
    // R2: arms cleared by reset, so a new event then 0-write keeps flag
    ev = 8'h01;
    @(posedge clk); @(negedge clk); idle();
    sel = 1'b1; wr = 1'b1;
    @(posedge clk); @(negedge clk); idle();
    check("R2 arm reset", {24'b0, flag}, 32'h01);

    finish_run();
  end
endmodule